// File: doc/BRIEF.md
# Calendar Counter with Alarm Compare

This block is a real-time clock core for a memory-mapped peripheral space. It keeps the current calendar as two packed binary words. The date word holds the full year, the month and the day. The time word holds hours, minutes and seconds. Both words advance once per second. The one-second tick comes from a prescaler that counts strobes of a 32.768 kHz oscillator, which are delivered as one-cycle pulses in the system clock domain. The prescaler divides by a programmable divider.

Software reads and writes the calendar words, the divider/trim word, a pair of alarm words and a status word through a simple register bus. The bus has an address, a write enable, write data and combinational read data. On a second tick, if the advanced date and time equal the alarm pair in all six fields, a sticky detect flag is set. The interrupt output is the flag gated by an enable bit. Month lengths, including February 29 under the Gregorian leap rule, drive the day-to-month carry.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the time word (0x10) reads 0, the date word (0x14) reads year 2000, month 1, day 1, the status word (0x08) reads 0, both alarm words read 0, and the divider/trim word (0x0C) reads 0x00007FFF.
- R2: With divider value N in bits 15:0 of 0x0C, `sec_tick` pulses once per N+1 oscillator strobes, and each pulse advances the time word by one second.
- R3: Writing zero to 0x0C loads 0x00007FFF (divider 32767, trim 0). Any other value is stored as written and read back whole, with trim in bits 31:16.
- R4: The time word packs hour in bits 16:12, minute in 11:6 and second in 5:0. Seconds wrap 59 to 0 into minutes, minutes wrap 59 to 0 into hours, and hours wrap 23 to 0 into the day.
- R5: The date word packs year in bits 20:9, month (1-12) in 8:5 and day in 4:0. The last day of a month rolls to day 1 of the next month. December 31 rolls to January 1 of the next year.
- R6: February has 29 days when the year is divisible by 4 and not by 100, or is divisible by 400. Otherwise it has 28 days (2024 and 2000 leap, 2100 not).
- R7: A write to the time or date word takes effect at once and restarts the prescaler, so the next tick comes N+1 strobes after the write.
- R8: The alarm time word (0x18) and alarm date word (0x1C) use the calendar layouts. Status bit 4 is set on a tick whose new date and time equal the alarm in all six fields. A difference in any one field sets nothing.
- R9: `alarm_irq` is high only while both status bit 4 (detect) and status bit 5 (enable) are set. The detect flag is set whether or not enable is set.
- R10: Writing 1 to status bit 4 clears the detect flag. Writing 0 there leaves it unchanged. Bit 5 is written as given.
- R11: A direct write that makes the calendar equal the alarm does not set the detect flag. Only a tick does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle strobe per 32.768 kHz oscillator period |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sec_tick | output | 1 | One-cycle pulse on each one-second tick |
| alarm_irq | output | 1 | Alarm interrupt (detect AND enable) |

## Verification
The hardest states to reach from the ports are the carry chains that ripple all the way into the year, and the February boundaries in leap, century and 400-year years. At the default divide ratio, reaching them takes days of simulated ticks. The stimulus therefore first programs a divider of 3, so a second costs four strobes. It then writes a calendar one or two seconds short of each boundary and reads both words back after the ticks. Alarm matching is driven the same way: the calendar is placed just before the alarm value, and separate cases change a single field or write the matching value directly, to show that neither sets the flag.

// File: rtl/rtc_pkg.sv
// Package: shared calendar types and month-length helpers.
// Assumes binary (not BCD) fields and a full calendar year.
package rtc_pkg;
    localparam int REG_W = 32;

    typedef struct packed {
        logic [11:0] year;
        logic [3:0]  month;
        logic [4:0]  day;
    } rtc_date_t;

    typedef struct packed {
        logic [4:0] hour;
        logic [5:0] minute;
        logic [5:0] second;
    } rtc_time_t;

    // Gregorian leap rule
    function automatic logic is_leap(input logic [11:0] y);
        int yi;
        yi = int'(y);
        return ((yi % 4 == 0) && (yi % 100 != 0)) || (yi % 400 == 0);
    endfunction

    // Number of days in a month for a given leap status
    function automatic logic [4:0] month_len(input logic [3:0] m, input logic leap);
        case (m)
            4'd2:                    return leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            default:                 return 5'd31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_prescaler.sv
// Module: rtc_prescaler
// Counts oscillator strobes and emits a one-cycle tick every (divider+1)
// strobes. Assumes osc_tick is already synchronous to clk. A restart
// clears the count and suppresses a tick in the same cycle.
module rtc_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic             restart,
    input  logic [DIV_W-1:0] divider,
    output logic             sec_tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             at_end;

    // Terminal count; >= keeps a lowered divider from stalling the count
    assign at_end   = (cnt_q >= divider);
    assign sec_tick = osc_tick && !restart && at_end;

    // Strobe counter with restart
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (restart)       cnt_q <= '0;
        else if (osc_tick)      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end

    // R2
    presc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> (cnt_q == '0));
    // R2
    presc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_tick && !restart) |=> $stable(cnt_q));
    // R7
    presc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_datetime.sv
// Module: rtc_datetime
// Holds the running time and date words and computes their one-second
// successor. A word write has priority over a tick for that word.
// Out-of-range field values are treated as the wrap point.
module rtc_datetime
    import rtc_pkg::*;
#(
    parameter int RESET_YEAR = 2000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sec_tick,
    input  logic      time_we,
    input  rtc_time_t time_wdata,
    input  logic      date_we,
    input  rtc_date_t date_wdata,
    output rtc_time_t cur_time,
    output rtc_date_t cur_date,
    output rtc_time_t next_time,
    output rtc_date_t next_date
);
    logic sec_wrap, min_wrap, hour_wrap, day_end, year_end;
    logic [4:0] mlen;

    // Carry chain from seconds up to the year
    always_comb begin
        sec_wrap  = (cur_time.second >= 6'd59);
        min_wrap  = sec_wrap && (cur_time.minute >= 6'd59);
        hour_wrap = min_wrap && (cur_time.hour >= 5'd23);
        mlen      = month_len(cur_date.month, is_leap(cur_date.year));
        day_end   = hour_wrap && (cur_date.day >= mlen);
        year_end  = day_end && (cur_date.month >= 4'd12);

        next_time.second = sec_wrap  ? 6'd0 : cur_time.second + 6'd1;
        next_time.minute = !sec_wrap ? cur_time.minute :
                           (min_wrap ? 6'd0 : cur_time.minute + 6'd1);
        next_time.hour   = !min_wrap ? cur_time.hour :
                           (hour_wrap ? 5'd0 : cur_time.hour + 5'd1);

        next_date.day    = !hour_wrap ? cur_date.day :
                           (day_end ? 5'd1 : cur_date.day + 5'd1);
        next_date.month  = !day_end ? cur_date.month :
                           (year_end ? 4'd1 : cur_date.month + 4'd1);
        next_date.year   = year_end ? cur_date.year + 12'd1 : cur_date.year;
    end

    // Time word register
    always_ff @(posedge clk) begin
        if (!rst_n)        cur_time <= '0;
        else if (time_we)  cur_time <= time_wdata;
        else if (sec_tick) cur_time <= next_time;
    end

    // Date word register
    always_ff @(posedge clk) begin
        if (!rst_n)        cur_date <= '{year: 12'(RESET_YEAR), month: 4'd1, day: 5'd1};
        else if (date_we)  cur_date <= date_wdata;
        else if (sec_tick) cur_date <= next_date;
    end

    // R4
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !time_we && cur_time.second < 6'd59)
        |=> cur_time.second == $past(cur_time.second) + 6'd1);
    // R2
    time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !time_we) |=> $stable(cur_time));
    // R5
    date_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !date_we) |=> $stable(cur_date));
endmodule

// File: rtl/rtc_alarm_unit.sv
// Module: rtc_alarm_unit
// Stores the alarm date/time pair, the detect flag and its enable.
// The comparison uses the calendar value the tick is about to load,
// so the flag rises on the same edge the calendar reaches the alarm.
module rtc_alarm_unit
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sec_tick,
    input  rtc_time_t next_time,
    input  rtc_date_t next_date,
    input  logic      atime_we,
    input  rtc_time_t atime_wdata,
    input  logic      adate_we,
    input  rtc_date_t adate_wdata,
    input  logic      stat_we,
    input  logic      clr_flag,
    input  logic      en_wdata,
    output rtc_time_t alarm_time,
    output rtc_date_t alarm_date,
    output logic      flag_q,
    output logic      en_q
);
    logic hit;

    // Full six-field match, only on a tick
    assign hit = sec_tick && (next_time == alarm_time) && (next_date == alarm_date);

    // Alarm word registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_time <= '0;
            alarm_date <= '0;
        end else begin
            if (atime_we) alarm_time <= atime_wdata;
            if (adate_we) alarm_date <= adate_wdata;
        end
    end

    // Sticky detect flag (set wins over clear) and enable bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            if (hit)                      flag_q <= 1'b1;
            else if (stat_we && clr_flag) flag_q <= 1'b0;
            if (stat_we)                  en_q   <= en_wdata;
        end
    end

    // R11
    flag_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(sec_tick));
    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && clr_flag && !sec_tick) |=> !flag_q);
endmodule

// File: rtl/rtc_calendar_core.sv
// Module: rtc_calendar_core (top)
// Register decode, divider/trim storage and read multiplexer around the
// prescaler, calendar and alarm units. Assumes a single clock domain and
// word-wide accesses; unmapped addresses read zero and ignore writes.
module rtc_calendar_core
    import rtc_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int DEFAULT_DIV = 32767,
    parameter int RESET_YEAR  = 2000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        osc_tick,
    input  logic [7:0]  bus_addr,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        sec_tick,
    output logic        alarm_irq
);
    localparam logic [7:0] A_STAT  = 8'h08;
    localparam logic [7:0] A_TRIM  = 8'h0C;
    localparam logic [7:0] A_TIME  = 8'h10;
    localparam logic [7:0] A_DATE  = 8'h14;
    localparam logic [7:0] A_ATIME = 8'h18;
    localparam logic [7:0] A_ADATE = 8'h1C;
    localparam int FLAG_BIT = 4;
    localparam int EN_BIT   = 5;
    localparam logic [REG_W-1:0] TRIM_DEFAULT = REG_W'(DEFAULT_DIV);

    logic [REG_W-1:0] trim_q;
    logic we_stat, we_trim, we_time, we_date, we_atime, we_adate;
    rtc_time_t cur_time, next_time, alarm_time;
    rtc_date_t cur_date, next_date, alarm_date;
    logic flag_q, en_q;

    // Write strobes per register
    assign we_stat  = bus_we && (bus_addr == A_STAT);
    assign we_trim  = bus_we && (bus_addr == A_TRIM);
    assign we_time  = bus_we && (bus_addr == A_TIME);
    assign we_date  = bus_we && (bus_addr == A_DATE);
    assign we_atime = bus_we && (bus_addr == A_ATIME);
    assign we_adate = bus_we && (bus_addr == A_ADATE);

    // Divider/trim register; zero substitutes the default divider
    always_ff @(posedge clk) begin
        if (!rst_n)       trim_q <= TRIM_DEFAULT;
        else if (we_trim) trim_q <= (bus_wdata == '0) ? TRIM_DEFAULT : bus_wdata;
    end

    rtc_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .restart  (we_time || we_date),
        .divider  (trim_q[DIV_W-1:0]),
        .sec_tick (sec_tick)
    );

    rtc_datetime #(.RESET_YEAR(RESET_YEAR)) u_cal (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_tick   (sec_tick),
        .time_we    (we_time),
        .time_wdata (rtc_time_t'(bus_wdata[16:0])),
        .date_we    (we_date),
        .date_wdata (rtc_date_t'(bus_wdata[20:0])),
        .cur_time   (cur_time),
        .cur_date   (cur_date),
        .next_time  (next_time),
        .next_date  (next_date)
    );

    rtc_alarm_unit u_alarm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sec_tick    (sec_tick),
        .next_time   (next_time),
        .next_date   (next_date),
        .atime_we    (we_atime),
        .atime_wdata (rtc_time_t'(bus_wdata[16:0])),
        .adate_we    (we_adate),
        .adate_wdata (rtc_date_t'(bus_wdata[20:0])),
        .stat_we     (we_stat),
        .clr_flag    (bus_wdata[FLAG_BIT]),
        .en_wdata    (bus_wdata[EN_BIT]),
        .alarm_time  (alarm_time),
        .alarm_date  (alarm_date),
        .flag_q      (flag_q),
        .en_q        (en_q)
    );

    assign alarm_irq = flag_q && en_q;

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_STAT:  begin
                bus_rdata[FLAG_BIT] = flag_q;
                bus_rdata[EN_BIT]   = en_q;
            end
            A_TRIM:  bus_rdata = trim_q;
            A_TIME:  bus_rdata = REG_W'(cur_time);
            A_DATE:  bus_rdata = REG_W'(cur_date);
            A_ATIME: bus_rdata = REG_W'(alarm_time);
            A_ADATE: bus_rdata = REG_W'(alarm_date);
            default: bus_rdata = '0;
        endcase
    end

    // R3
    trim_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trim_q != '0);
    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_stat && !bus_wdata[EN_BIT]) |=> !alarm_irq);
endmodule

// File: tb/sim_rtc_calendar_core.sv
module sim_rtc_calendar_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sec_tick;
    logic        alarm_irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Scoreboard queues: kind 0 = read data, kind 1 = alarm_irq pin
    bit          q_kind[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    rtc_calendar_core u0 (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .sec_tick(sec_tick), .alarm_irq(alarm_irq)
    );

    function automatic logic [31:0] pk_date(int y, int m, int d);
        return (32'(y) << 9) | (32'(m) << 5) | 32'(d);
    endfunction
    function automatic logic [31:0] pk_time(int h, int mi, int s);
        return (32'(h) << 12) | (32'(mi) << 6) | 32'(s);
    endfunction

    // Monitor: compares the oldest expected item shortly after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() > 0) begin
                bit k;
                logic [31:0] e, a;
                string t;
                k = q_kind.pop_front();
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                a = k ? {31'b0, alarm_irq} : bus_rdata;
                total++;
                if (a !== e) begin
                    bad++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", t, bus_addr, a, e);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic expect_item(input bit k, input logic [7:0] a,
                               input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr = a;
        q_kind.push_back(k); q_exp.push_back(e); q_tag.push_back(t);
        @(posedge clk);
        #2;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); osc_tick = 1'b1;
            @(negedge clk); osc_tick = 1'b0;
        end
    endtask

    task automatic set_cal(input logic [31:0] d, input logic [31:0] t);
        wr(8'h14, d);
        wr(8'h10, t);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        expect_item(0, 8'h10, 32'h0, "R1 time");
        expect_item(0, 8'h14, pk_date(2000, 1, 1), "R1 date");
        expect_item(0, 8'h08, 32'h0, "R1 status");
        expect_item(0, 8'h18, 32'h0, "R1 alarm time");
        expect_item(0, 8'h1C, 32'h0, "R1 alarm date");
        expect_item(0, 8'h0C, 32'h00007FFF, "R1 trim");

        // R3 trim register
        wr(8'h0C, 32'h00050003);
        expect_item(0, 8'h0C, 32'h00050003, "R3 stored");
        wr(8'h0C, 32'h0);
        expect_item(0, 8'h0C, 32'h00007FFF, "R3 zero default");
        wr(8'h0C, 32'h00000003);

        // R2 period of four strobes with divider 3
        set_cal(pk_date(2023, 5, 10), pk_time(10, 20, 30));
        pulses(3);
        expect_item(0, 8'h10, pk_time(10, 20, 30), "R2 before tick");
        pulses(1);
        expect_item(0, 8'h10, pk_time(10, 20, 31), "R2 after tick");

        // R7 write restarts the prescaler
        pulses(2);
        wr(8'h10, pk_time(1, 2, 3));
        pulses(3);
        expect_item(0, 8'h10, pk_time(1, 2, 3), "R7 no early tick");
        pulses(1);
        expect_item(0, 8'h10, pk_time(1, 2, 4), "R7 full period");

        // R4 minute to hour carry
        wr(8'h10, pk_time(10, 59, 59));
        pulses(4);
        expect_item(0, 8'h10, pk_time(11, 0, 0), "R4 hour carry");

        // R4 R5 year end
        set_cal(pk_date(2023, 12, 31), pk_time(23, 59, 58));
        pulses(8);
        expect_item(0, 8'h10, pk_time(0, 0, 0), "R4 day wrap");
        expect_item(0, 8'h14, pk_date(2024, 1, 1), "R5 new year");

        // R5 month lengths
        set_cal(pk_date(2023, 4, 30), pk_time(23, 59, 59));
        pulses(4);
        expect_item(0, 8'h14, pk_date(2023, 5, 1), "R5 30-day month");
        set_cal(pk_date(2023, 1, 31), pk_time(23, 59, 59));
        pulses(4);
        expect_item(0, 8'h14, pk_date(2023, 2, 1), "R5 31-day month");

        // R6 leap rule
        set_cal(pk_date(2024, 2, 28), pk_time(23, 59, 59));
        pulses(4);
        expect_item(0, 8'h14, pk_date(2024, 2, 29), "R6 2024 leap");
        wr(8'h10, pk_time(23, 59, 59));
        pulses(4);
        expect_item(0, 8'h14, pk_date(2024, 3, 1), "R6 after feb 29");
        set_cal(pk_date(2100, 2, 28), pk_time(23, 59, 59));
        pulses(4);
        expect_item(0, 8'h14, pk_date(2100, 3, 1), "R6 2100 common");
        set_cal(pk_date(2000, 2, 28), pk_time(23, 59, 59));
        pulses(4);
        expect_item(0, 8'h14, pk_date(2000, 2, 29), "R6 2000 leap");

        // R8 alarm match, enable off
        wr(8'h18, pk_time(8, 30, 5));
        wr(8'h1C, pk_date(2024, 6, 15));
        expect_item(0, 8'h18, pk_time(8, 30, 5), "R8 alarm time readback");
        set_cal(pk_date(2024, 6, 15), pk_time(8, 30, 3));
        pulses(4);
        expect_item(0, 8'h08, 32'h0, "R8 one second early");
        pulses(4);
        expect_item(0, 8'h08, 32'h10, "R8 match sets flag");
        expect_item(1, 8'h08, 32'h0, "R9 irq masked");

        // R9 R10 enable and clear
        wr(8'h08, 32'h20);
        expect_item(0, 8'h08, 32'h30, "R10 zero keeps flag");
        expect_item(1, 8'h08, 32'h1, "R9 irq asserted");
        wr(8'h08, 32'h30);
        expect_item(0, 8'h08, 32'h20, "R10 clear");
        expect_item(1, 8'h08, 32'h0, "R9 irq dropped");

        // R11 direct write to the alarm value
        wr(8'h10, pk_time(8, 30, 5));
        expect_item(0, 8'h08, 32'h20, "R11 write no flag");

        // R8 partial match: date differs by one day
        wr(8'h1C, pk_date(2024, 6, 16));
        wr(8'h10, pk_time(8, 30, 4));
        pulses(4);
        expect_item(0, 8'h10, pk_time(8, 30, 5), "R8 time advanced");
        expect_item(0, 8'h08, 32'h20, "R8 partial no flag");
        expect_item(1, 8'h08, 32'h0, "R9 partial no irq");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule